// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address after a translation lookaside buffer miss. It walks a two-level table held in ordinary memory. The walk starts at a directory whose 4 KB frame is named by a root base input. The high index field of the virtual address selects a directory entry. That entry names the frame of a second-level table. The middle index field then selects the leaf entry. The leaf entry supplies the physical frame. The 12-bit page offset is carried across unchanged.

The walker serves one request at a time. It issues its two memory reads strictly in order through a single-outstanding read port with a valid/ready request phase and a separate response strobe. Each table entry is 4 bytes wide. Bit 0 of an entry marks it present, and bits 31:12 hold a frame number. A missing entry at either level ends the walk with a fault that names the level. A successful walk returns the physical address and, in the same cycle, an install record (virtual page number and physical frame number) for the translation buffer.

Top module: `page_walker`

## Requirements
- R1: After reset the walker is idle: `reqReady` is 1 and `memReqValid`, `doneValid`, `faultValid` and `tlbFillValid` are 0.
- R2: The first read of a walk goes to `{rootBase, vaddr[31:22], 2'b00}`, which is the directory frame base plus the directory index times 4.
- R3: The second read goes to `{dirEntry[31:12], vaddr[21:12], 2'b00}`. It is issued only after the directory response has arrived with bit 0 set.
- R4: A walk whose two entries both have bit 0 set raises `doneValid` for exactly one cycle, with `donePaddr = {leafEntry[31:12], vaddr[11:0]}`.
- R5: In the cycle of `doneValid`, `tlbFillValid` is 1, `tlbFillVpn = vaddr[31:12]` and `tlbFillPfn = leafEntry[31:12]`. On a fault, `tlbFillValid` stays 0.
- R6: A directory entry with bit 0 clear raises `faultValid` for one cycle with `faultLevel = 0`. No second read is issued.
- R7: A leaf entry with bit 0 clear raises `faultValid` for one cycle with `faultLevel = 1`. `doneValid` and `faultValid` are never high together.
- R8: `reqReady` is 0 from acceptance until the walk ends. Requests presented meanwhile are ignored and do not change the reads issued or the result.
- R9: While `memReqValid` is 1 and `memReqReady` is 0, the request stays valid and `memReqAddr` stays stable.
- R10: At most one read is outstanding. After a request is accepted, `memReqValid` stays 0 until its response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Walk request strobe |
| reqVaddr | input | 32 | Virtual address to translate |
| reqReady | output | 1 | Walker idle and able to accept a request |
| rootBase | input | 20 | Frame number of the directory |
| memReqValid | output | 1 | Memory read request valid |
| memReqAddr | output | 32 | Byte address of the entry to read |
| memReqReady | input | 1 | Memory accepts the read |
| memRespValid | input | 1 | Read data valid |
| memRespData | input | 32 | Entry read from memory |
| doneValid | output | 1 | One-cycle strobe: translation complete |
| donePaddr | output | 32 | Translated physical address |
| faultValid | output | 1 | One-cycle strobe: walk failed |
| faultLevel | output | 1 | Level of the missing entry: 0 directory, 1 leaf |
| tlbFillValid | output | 1 | Install strobe for the translation buffer |
| tlbFillVpn | output | 20 | Virtual page number to install |
| tlbFillPfn | output | 20 | Physical frame number to install |

## Verification
The bench builds the walker with its default split of 10 directory bits, 10 leaf bits and 12 offset bits, and with 4-byte entries. The memory model is therefore addressed with full 32-bit entry addresses. Index values 0 and 1023 at both levels can be reached, as can frames at the very top of the physical space. The model also varies the acceptance stall and the response latency, so the hold rule on the request and the single-outstanding rule are exercised under back-pressure as well as with zero-wait memory.

// File: rtl/walker_pkg.sv
package walker_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_TBL_REQ,
    ST_TBL_WAIT,
    ST_DONE,
    ST_FAULT
  } walkState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureReq;   // latch the virtual address
    logic captureDir;   // latch next-table base from directory entry
    logic captureTbl;   // latch frame from leaf entry
    logic selTable;     // address mux: 0 directory, 1 leaf table
  } walkStrobe_t;

endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReqReady,
  input  logic        memRespValid,
  input  logic        entryPresent,
  output walkStrobe_t strobe,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        doneValid,
  output logic        faultValid,
  output logic        faultLevel
);

  walkState_t stateQ, stateD;
  logic       faultLevelQ, faultLevelD;

  always_comb begin
    stateD      = stateQ;
    faultLevelD = faultLevelQ;
    unique case (stateQ)
      ST_IDLE:     if (reqValid) stateD = ST_DIR_REQ;
      ST_DIR_REQ:  if (memReqReady) stateD = ST_DIR_WAIT;
      ST_DIR_WAIT: if (memRespValid) begin
                     if (entryPresent) stateD = ST_TBL_REQ;
                     else begin
                       stateD      = ST_FAULT;
                       faultLevelD = 1'b0;
                     end
                   end
      ST_TBL_REQ:  if (memReqReady) stateD = ST_TBL_WAIT;
      ST_TBL_WAIT: if (memRespValid) begin
                     if (entryPresent) stateD = ST_DONE;
                     else begin
                       stateD      = ST_FAULT;
                       faultLevelD = 1'b1;
                     end
                   end
      ST_DONE:     stateD = ST_IDLE;
      ST_FAULT:    stateD = ST_IDLE;
      default:     stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      faultLevelQ <= 1'b0;
    end else begin
      stateQ      <= stateD;
      faultLevelQ <= faultLevelD;
    end
  end

  always_comb begin
    strobe.captureReq = (stateQ == ST_IDLE) && reqValid;
    strobe.captureDir = (stateQ == ST_DIR_WAIT) && memRespValid && entryPresent;
    strobe.captureTbl = (stateQ == ST_TBL_WAIT) && memRespValid && entryPresent;
    strobe.selTable   = (stateQ == ST_TBL_REQ) || (stateQ == ST_TBL_WAIT);
  end

  assign reqReady    = (stateQ == ST_IDLE);
  assign memReqValid = (stateQ == ST_DIR_REQ) || (stateQ == ST_TBL_REQ);
  assign doneValid   = (stateQ == ST_DONE);
  assign faultValid  = (stateQ == ST_FAULT);
  assign faultLevel  = faultLevelQ;

  // R4: completion strobe lasts one cycle
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R6: fault strobe lasts one cycle
  assert_fault_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> !faultValid);

  // R10: accepted read is followed by a quiet request line
  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !memReqValid);

  // R8: no new request accepted while a read is in flight
  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

endmodule

// File: rtl/walk_datapath.sv
module walk_datapath
  import walker_pkg::*;
#(
  parameter int DIR_IDX_W   = 10,
  parameter int TBL_IDX_W   = 10,
  parameter int OFF_W       = 12,
  parameter int PA_W        = 32,
  parameter int ENTRY_BYTES = 4,
  parameter int PRESENT_BIT = 0,
  localparam int VA_W        = DIR_IDX_W + TBL_IDX_W + OFF_W,
  localparam int FRAME_W     = PA_W - OFF_W,
  localparam int VPN_W       = VA_W - OFF_W,
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES)
)(
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobe_t        strobe,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic [FRAME_W-1:0] rootBase,
  input  logic [PA_W-1:0]    memRespData,
  output logic [PA_W-1:0]    memReqAddr,
  output logic               entryPresent,
  output logic [PA_W-1:0]    physAddr,
  output logic [VPN_W-1:0]   fillVpn,
  output logic [FRAME_W-1:0] fillPfn
);

  logic [VA_W-1:0]      vaddrQ;
  logic [FRAME_W-1:0]   tableBaseQ;
  logic [FRAME_W-1:0]   frameQ;
  logic [DIR_IDX_W-1:0] dirIdx;
  logic [TBL_IDX_W-1:0] tblIdx;
  logic [FRAME_W-1:0]   entryFrame;
  logic [PA_W-1:0]      dirAddr, tblAddr;

  assign dirIdx     = vaddrQ[VA_W-1 -: DIR_IDX_W];
  assign tblIdx     = vaddrQ[OFF_W +: TBL_IDX_W];
  assign entryFrame = memRespData[PA_W-1:OFF_W];
  assign entryPresent = memRespData[PRESENT_BIT];

  // Entry address: frame base plus index scaled by entry size
  assign dirAddr = {rootBase, {OFF_W{1'b0}}} + (PA_W'(dirIdx) << ENTRY_SHIFT);
  assign tblAddr = {tableBaseQ, {OFF_W{1'b0}}} + (PA_W'(tblIdx) << ENTRY_SHIFT);
  assign memReqAddr = strobe.selTable ? tblAddr : dirAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ     <= '0;
      tableBaseQ <= '0;
      frameQ     <= '0;
    end else begin
      if (strobe.captureReq) vaddrQ     <= reqVaddr;
      if (strobe.captureDir) tableBaseQ <= entryFrame;
      if (strobe.captureTbl) frameQ     <= entryFrame;
    end
  end

  assign physAddr = {frameQ, vaddrQ[OFF_W-1:0]};
  assign fillVpn  = vaddrQ[VA_W-1:OFF_W];
  assign fillPfn  = frameQ;

  // R8: the virtual address is frozen while the walk is in the leaf phase
  assert_vaddr_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.selTable && $past(strobe.selTable)) |-> $stable(vaddrQ));

endmodule

// File: rtl/page_walker.sv
module page_walker
  import walker_pkg::*;
#(
  parameter int DIR_IDX_W   = 10,
  parameter int TBL_IDX_W   = 10,
  parameter int OFF_W       = 12,
  parameter int PA_W        = 32,
  parameter int ENTRY_BYTES = 4,
  localparam int VA_W    = DIR_IDX_W + TBL_IDX_W + OFF_W,
  localparam int FRAME_W = PA_W - OFF_W,
  localparam int VPN_W   = VA_W - OFF_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [VA_W-1:0]    reqVaddr,
  output logic               reqReady,
  input  logic [FRAME_W-1:0] rootBase,
  output logic               memReqValid,
  output logic [PA_W-1:0]    memReqAddr,
  input  logic               memReqReady,
  input  logic               memRespValid,
  input  logic [PA_W-1:0]    memRespData,
  output logic               doneValid,
  output logic [PA_W-1:0]    donePaddr,
  output logic               faultValid,
  output logic               faultLevel,
  output logic               tlbFillValid,
  output logic [VPN_W-1:0]   tlbFillVpn,
  output logic [FRAME_W-1:0] tlbFillPfn
);

  walkStrobe_t strobe;
  logic        entryPresent;

  walk_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .entryPresent (entryPresent),
    .strobe       (strobe),
    .reqReady     (reqReady),
    .memReqValid  (memReqValid),
    .doneValid    (doneValid),
    .faultValid   (faultValid),
    .faultLevel   (faultLevel)
  );

  walk_datapath #(
    .DIR_IDX_W   (DIR_IDX_W),
    .TBL_IDX_W   (TBL_IDX_W),
    .OFF_W       (OFF_W),
    .PA_W        (PA_W),
    .ENTRY_BYTES (ENTRY_BYTES),
    .PRESENT_BIT (0)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqVaddr     (reqVaddr),
    .rootBase     (rootBase),
    .memRespData  (memRespData),
    .memReqAddr   (memReqAddr),
    .entryPresent (entryPresent),
    .physAddr     (donePaddr),
    .fillVpn      (tlbFillVpn),
    .fillPfn      (tlbFillPfn)
  );

  assign tlbFillValid = doneValid;

  // R9: a stalled request holds its address
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  // R7: success and fault are exclusive
  assert_done_xor_fault_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(doneValid && faultValid));

  // R1: idle walker asserts no strobes
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !(memReqValid || doneValid || faultValid));

endmodule

// File: tb/tb_page_walker.sv
module tb_page_walker;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [31:0] reqVaddr;
  logic        reqReady;
  logic [19:0] rootBase;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memReqReady;
  logic        memRespValid;
  logic [31:0] memRespData;
  logic        doneValid;
  logic [31:0] donePaddr;
  logic        faultValid;
  logic        faultLevel;
  logic        tlbFillValid;
  logic [19:0] tlbFillVpn;
  logic [19:0] tlbFillPfn;

  always #4 clk = ~clk;  // 125 MHz

  page_walker dut (.*);

  typedef struct {
    bit          isFault;
    bit          level;
    logic [31:0] pa;
    logic [19:0] vpn;
    logic [19:0] pfn;
  } expItem_t;

  typedef struct {
    logic [31:0] addr;
    int          lvl;
  } expRead_t;

  expItem_t    expQ[$];
  expRead_t    readQ[$];
  logic [31:0] mem [logic [31:0]];
  int          checks = 0;
  int          errors = 0;
  int          stallN = 0;
  int          latN   = 0;
  bit          finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic mapPage(input logic [31:0] va, input logic [19:0] tblFrame,
                         input logic [19:0] pfn);
    mem[{rootBase, va[31:22], 2'b00}] = {tblFrame, 12'h001};
    mem[{tblFrame, va[21:12], 2'b00}] = {pfn, 12'h001};
  endtask

  // Driver: compute expectation, push, issue, wait for result
  task automatic doWalk(input logic [31:0] va, input bit spam);
    expItem_t    e;
    logic [31:0] de, pe, dAddr, tAddr;
    bit          busyOk = 1;
    dAddr = {rootBase, va[31:22], 2'b00};
    de    = rd(dAddr);
    readQ.push_back('{dAddr, 0});
    e = '{0, 0, 32'h0, va[31:12], 20'h0};
    if (!de[0]) begin
      e.isFault = 1; e.level = 0;
    end else begin
      tAddr = {de[31:12], va[21:12], 2'b00};
      pe    = rd(tAddr);
      readQ.push_back('{tAddr, 1});
      if (!pe[0]) begin
        e.isFault = 1; e.level = 1;
      end else begin
        e.pa  = {pe[31:12], va[11:0]};
        e.pfn = pe[31:12];
      end
    end
    expQ.push_back(e);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    reqVaddr = va;
    @(negedge clk);
    if (spam) reqVaddr = ~va;
    else reqValid = 1'b0;
    forever begin
      if (doneValid || faultValid) break;
      if (reqReady) busyOk = 0;
      @(negedge clk);
    end
    reqValid = 1'b0;
    if (spam) check(busyOk, "R8 reqReady low while busy", 32'(busyOk), 32'h1);
    @(negedge clk);
    check(expQ.size() == 0, "R4 result produced", expQ.size(), 0);
    check(readQ.size() == 0, "R3 all expected reads issued", readQ.size(), 0);
  endtask

  // Memory model with stall and latency
  initial begin
    memReqReady  = 1'b0;
    memRespValid = 1'b0;
    memRespData  = '0;
    forever begin
      @(negedge clk);
      if (memReqValid === 1'b1) begin
        logic [31:0] a;
        expRead_t    r;
        a = memReqAddr;
        for (int i = 0; i < stallN; i++) begin
          @(negedge clk);
          check(memReqValid === 1'b1 && memReqAddr == a, "R9 request held",
                memReqAddr, a);
        end
        if (readQ.size() == 0) begin
          check(0, "R6 unexpected read", a, 32'h0);
        end else begin
          r = readQ.pop_front();
          check(a == r.addr, r.lvl == 0 ? "R2 directory address" : "R3 table address",
                a, r.addr);
        end
        memReqReady = 1'b1;
        @(negedge clk);
        memReqReady = 1'b0;
        check(memReqValid == 1'b0, "R10 single outstanding", 32'(memReqValid), 32'h0);
        for (int i = 0; i < latN; i++) begin
          @(negedge clk);
          check(memReqValid == 1'b0, "R10 quiet during latency",
                32'(memReqValid), 32'h0);
        end
        memRespData  = rd(a);
        memRespValid = 1'b1;
        @(negedge clk);
        memRespValid = 1'b0;
        memRespData  = 32'hDEAD_BEEE;
      end
    end
  end

  // Monitor / scoreboard
  initial begin
    bit prevStrobe = 0;
    forever begin
      @(negedge clk);
      if (rstN && (doneValid || faultValid)) begin
        expItem_t e;
        check(!prevStrobe, "R4 one-cycle strobe", 32'(prevStrobe), 32'h0);
        check(!(doneValid && faultValid), "R7 exclusive strobes",
              {30'h0, doneValid, faultValid}, 32'h0);
        if (expQ.size() == 0) begin
          check(0, "R4 unexpected result", donePaddr, 32'h0);
        end else begin
          e = expQ.pop_front();
          if (e.isFault) begin
            check(faultValid, "R6 fault expected", 32'(faultValid), 32'h1);
            check(faultLevel == e.level, e.level ? "R7 fault level" : "R6 fault level",
                  32'(faultLevel), 32'(e.level));
            check(!tlbFillValid, "R5 no fill on fault", 32'(tlbFillValid), 32'h0);
          end else begin
            check(doneValid, "R4 done expected", 32'(doneValid), 32'h1);
            check(donePaddr == e.pa, "R4 physical address", donePaddr, e.pa);
            check(tlbFillValid, "R5 fill valid", 32'(tlbFillValid), 32'h1);
            check(tlbFillVpn == e.vpn, "R5 fill vpn", 32'(tlbFillVpn), 32'(e.vpn));
            check(tlbFillPfn == e.pfn, "R5 fill pfn", 32'(tlbFillPfn), 32'(e.pfn));
          end
        end
        prevStrobe = 1;
      end else begin
        prevStrobe = 0;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN     = 1'b0;
    reqValid = 1'b0;
    reqVaddr = '0;
    rootBase = 20'h00100;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1 ready after reset", 32'(reqReady), 32'h1);
    check({memReqValid, doneValid, faultValid, tlbFillValid} == 4'b0,
          "R1 strobes low after reset",
          {28'h0, memReqValid, doneValid, faultValid, tlbFillValid}, 32'h0);

    // R2 R3 R4 R5: basic walk, zero wait
    mapPage(32'h1234_5678, 20'h00200, 20'hABCDE);
    doWalk(32'h1234_5678, 0);

    // same directory entry, different leaf index, with back-pressure
    mapPage(32'h1237_F123, 20'h00200, 20'h13579);
    stallN = 2; latN = 3;
    doWalk(32'h1237_F123, 0);

    // index boundaries: all zero and all ones
    mapPage(32'h0000_0000, 20'h00300, 20'h00001);
    mapPage(32'hFFFF_FFFF, 20'hFFFFE, 20'hFFFFF);
    stallN = 0; latN = 1;
    doWalk(32'h0000_0000, 0);
    stallN = 3; latN = 0;
    doWalk(32'hFFFF_FFFF, 0);

    // R6: directory entry missing
    stallN = 1; latN = 2;
    doWalk(32'h4000_0ABC, 0);

    // R7: directory present, leaf missing
    mem[{rootBase, 10'h300, 2'b00}] = {20'h00400, 12'h001};
    mem[{20'h00400, 10'h005, 2'b00}] = {20'h77777, 12'h000};
    doWalk({10'h300, 10'h005, 12'h321}, 0);

    // R8: requests held high during a walk are ignored
    stallN = 2; latN = 2;
    doWalk(32'h1234_5678, 1);
    doWalk(32'h4000_0ABC, 1);

    // new root base
    rootBase = 20'h0F000;
    mapPage(32'h8765_4321, 20'h0F001, 20'h24680);
    stallN = 0; latN = 0;
    doWalk(32'h8765_4321, 0);

    repeat (4) @(negedge clk);
    check(reqReady == 1'b1, "R1 idle at end", 32'(reqReady), 32'h1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule